// File: doc/BRIEF.md
# HDLC Frame Transmitter with Underrun Abort

This block turns packets held in a byte-wide transmit FIFO into an HDLC bit stream for a D channel. Each FIFO entry carries an end-of-packet marker, so several packets can sit in the FIFO one after another. For each packet the block sends an opening flag and then the packet bytes with zero-bit insertion. It closes the frame with a complemented CRC-16 frame check sequence and a closing flag.

The block moves one bit per cycle in which the external bit strobe and the channel grant are both high. When it holds the channel but has nothing to send, it fills the line with either flags or continuous ones, chosen by an input. If the FIFO runs dry partway through a packet, the frame is cut short with an abort byte and a sticky interrupt is raised. The unsent rest of that packet is then thrown away as it arrives. After every frame the request output drops, so the external arbiter runs a new round before the next packet.

Top module: `hdlc_tx_abort`

## Requirements
- R1: After reset, `req_o`, `fifo_pop_o` and `underrun_irq_o` are 0, and `tx_bit_o` is 1 while `grant_i` is low.
- R2: While `grant_i` is low, `tx_bit_o` is 1. The bit position advances only in a cycle where `bit_stb_i` and `grant_i` are both high; each such cycle consumes exactly one line bit.
- R3: With no frame in progress, the line carries an idle pattern in 8-bit units. `idle_flag_i`=1 sends the flag byte 0x7E (line order 0,1,1,1,1,1,1,0), and `idle_flag_i`=0 sends all ones.
- R4: The FIFO head is valid while `fifo_empty_i` is 0, with `fifo_data_i` holding the byte and `fifo_last_i` the end-of-packet marker. A one-cycle `fifo_pop_o` consumes the head. A frame starts only after a complete idle unit, if data is present. It is sent as the flag 0x7E, then the packet bytes LSB first, then the FCS, then the flag 0x7E.
- R5: In the byte and FCS fields, a 0 is inserted after every run of five consecutive 1s. This includes a run that ends the FCS, or ends the last byte before an abort. Flag, idle and abort bits are never stuffed.
- R6: The FCS is the reflected CRC-16-CCITT (polynomial 0x8408), starting from 0xFFFF and computed over the unstuffed byte bits. It is sent complemented, LSB first.
- R7: If a byte whose marker is 0 finishes and the FIFO is empty, the frame ends at once with the abort byte 0x7F sent LSB first (seven 1s then a 0), with no FCS and no closing flag. This is the only cause of an underrun.
- R8: An underrun sets `underrun_irq_o`. The flag stays at 1 until a cycle with `irq_clr_i` high, and a new underrun in that same cycle wins over the clear.
- R9: After an abort, FIFO entries are popped and discarded up to and including the next entry marked last. `fifo_pop_o` is never high while `fifo_empty_i` is high.
- R10: `req_o` is high while a frame is in progress, or while data is waiting and no release is pending. It is low for at least one cycle after each closing flag or abort.
- R11: Packets queued back to back produce separate frames, each with its own flags and FCS, split at the end-of-packet markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | Line bit strobe |
| grant_i | input | 1 | Channel access granted by the external arbiter |
| idle_flag_i | input | 1 | Idle fill select: 1 flags, 0 ones |
| irq_clr_i | input | 1 | Clears the underrun flag |
| fifo_data_i | input | 8 | FIFO head byte |
| fifo_last_i | input | 1 | FIFO head is the last byte of its packet |
| fifo_empty_i | input | 1 | FIFO holds no entry |
| fifo_pop_o | output | 1 | Consume the FIFO head |
| req_o | output | 1 | Channel access request |
| tx_bit_o | output | 1 | Serial line bit |
| underrun_irq_o | output | 1 | Sticky underrun interrupt |

## Verification
The assertions check on every cycle that:
- nothing advances without a strobe-and-grant cycle;
- the FIFO is never popped while it is empty;
- the underrun flag only rises after an empty FIFO, stays set until cleared, and clears on request;
- the request drops right after a closing flag.

The exact bit content needs the scenarios in the bench. This covers flag placement, stuffing positions, the FCS value, the abort sequence with a stuffed zero before it, discarding of the leftover bytes, and the single release cycle between queued packets. The bench predicts that content from its own bit-level model and compares it on every consumed bit.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int unsigned BYTE_BITS = 8;
  localparam logic [BYTE_BITS-1:0] FLAG_PAT  = 8'h7E;
  localparam logic [BYTE_BITS-1:0] ABORT_PAT = 8'h7F;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_FCS,
    ST_CLOSE,
    ST_ABORT
  } tx_state_e;
endpackage

// File: rtl/hdlc_crc_unit.sv
module hdlc_crc_unit #(
  parameter int unsigned CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY = 16'h8408,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic upd_i,
  input  logic bit_i,
  input  logic shift_i,
  output logic lsb_o
);
  logic [CRC_W-1:0] crc_q;
  logic fb;

  assign fb    = crc_q[0] ^ bit_i;
  assign lsb_o = crc_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= INIT;
    else if (init_i)  crc_q <= INIT;
    else if (upd_i)   crc_q <= (crc_q >> 1) ^ (fb ? POLY : '0);
    else if (shift_i) crc_q <= {1'b1, crc_q[CRC_W-1:1]};
  end
endmodule

// File: rtl/hdlc_zero_stuffer.sv
module hdlc_zero_stuffer #(
  parameter int unsigned RUN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,    // stuffing allowed at this position
  input  logic take_i,  // a line bit is consumed
  input  logic count_i, // consumed bit belongs to a stuffed field
  input  logic bit_i,
  output logic stuff_o
);
  localparam int unsigned CNT_W = $clog2(RUN + 1);
  localparam logic [CNT_W-1:0] RUN_V = CNT_W'(RUN);

  logic [CNT_W-1:0] cnt_q;

  assign stuff_o = en_i && (cnt_q == RUN_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (take_i) begin
      if (stuff_o)      cnt_q <= '0;
      else if (count_i) cnt_q <= bit_i ? cnt_q + CNT_W'(1) : '0;
    end
  end
endmodule

// File: rtl/hdlc_irq_flag.sv
module hdlc_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/hdlc_tx_abort.sv
module hdlc_tx_abort
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned BYTE_W    = BYTE_BITS,
  parameter int unsigned CRC_W     = 16,
  parameter int unsigned STUFF_RUN = 5,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              grant_i,
  input  logic              idle_flag_i,
  input  logic              irq_clr_i,
  input  logic [BYTE_W-1:0] fifo_data_i,
  input  logic              fifo_last_i,
  input  logic              fifo_empty_i,
  output logic              fifo_pop_o,
  output logic              req_o,
  output logic              tx_bit_o,
  output logic              underrun_irq_o
);
  localparam int unsigned IDX_W = $clog2(CRC_W);
  localparam int unsigned BIT_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] BYTE_END = IDX_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] FCS_END  = IDX_W'(CRC_W - 1);

  tx_state_e         st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              last_q, last_d;
  logic              drain_q, drain_d;
  logic              gap_q, gap_d;

  logic step, adv, stuff_en, stuff_now, cur_bit, line_bit;
  logic crc_lsb, crc_init, crc_upd, crc_shift;
  logic pop_start, pop_data, pop_drain, underrun_evt;
  logic in_field, start_ok;

  assign step     = bit_stb_i & grant_i;
  assign in_field = (st_q == ST_DATA) || (st_q == ST_FCS);
  assign stuff_en = in_field ||
                    (((st_q == ST_CLOSE) || (st_q == ST_ABORT)) && (idx_q == '0));
  assign adv      = step & ~stuff_now;
  assign start_ok = !fifo_empty_i && !drain_q && !gap_q;

  hdlc_zero_stuffer #(.RUN(STUFF_RUN)) u_stuff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   ((st_q == ST_IDLE) || (st_q == ST_OPEN)),
    .en_i    (stuff_en),
    .take_i  (step),
    .count_i (in_field),
    .bit_i   (cur_bit),
    .stuff_o (stuff_now)
  );

  hdlc_crc_unit #(.CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (crc_init),
    .upd_i   (crc_upd),
    .bit_i   (sh_q[0]),
    .shift_i (crc_shift),
    .lsb_o   (crc_lsb)
  );

  hdlc_irq_flag u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (underrun_evt),
    .clr_i  (irq_clr_i),
    .flag_o (underrun_irq_o)
  );

  // Bit presented on the line for the current position
  always_comb begin
    unique case (st_q)
      ST_IDLE:           cur_bit = idle_flag_i ? FLAG_PAT[idx_q[BIT_W-1:0]] : 1'b1;
      ST_OPEN, ST_CLOSE: cur_bit = FLAG_PAT[idx_q[BIT_W-1:0]];
      ST_DATA:           cur_bit = sh_q[0];
      ST_FCS:            cur_bit = ~crc_lsb;
      ST_ABORT:          cur_bit = ABORT_PAT[idx_q[BIT_W-1:0]];
      default:           cur_bit = 1'b1;
    endcase
  end

  assign line_bit   = stuff_now ? 1'b0 : cur_bit;
  assign tx_bit_o   = grant_i ? line_bit : 1'b1;
  assign fifo_pop_o = pop_start | pop_data | pop_drain;
  assign req_o      = (st_q != ST_IDLE) || start_ok;

  always_comb begin
    st_d = st_q;  idx_d = idx_q;  sh_d = sh_q;  last_d = last_q;
    drain_d = drain_q;  gap_d = 1'b0;
    pop_start = 1'b0;  pop_data = 1'b0;  pop_drain = 1'b0;  underrun_evt = 1'b0;
    crc_init = 1'b0;  crc_upd = 1'b0;  crc_shift = 1'b0;
    unique case (st_q)
      ST_IDLE: if (adv) begin
        if (idx_q == BYTE_END) begin
          idx_d = '0;
          if (start_ok) begin
            pop_start = 1'b1;
            sh_d      = fifo_data_i;
            last_d    = fifo_last_i;
            st_d      = ST_OPEN;
          end
        end else idx_d = idx_q + IDX_W'(1);
      end
      ST_OPEN: begin
        crc_init = 1'b1;
        if (adv) begin
          if (idx_q == BYTE_END) begin idx_d = '0; st_d = ST_DATA; end
          else idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_DATA: if (adv) begin
        crc_upd = 1'b1;
        sh_d    = {1'b0, sh_q[BYTE_W-1:1]};
        if (idx_q == BYTE_END) begin
          idx_d = '0;
          if (last_q) st_d = ST_FCS;
          else if (fifo_empty_i) begin
            underrun_evt = 1'b1;
            drain_d      = 1'b1;
            st_d         = ST_ABORT;
          end else begin
            pop_data = 1'b1;
            sh_d     = fifo_data_i;
            last_d   = fifo_last_i;
          end
        end else idx_d = idx_q + IDX_W'(1);
      end
      ST_FCS: if (adv) begin
        crc_shift = 1'b1;
        if (idx_q == FCS_END) begin idx_d = '0; st_d = ST_CLOSE; end
        else idx_d = idx_q + IDX_W'(1);
      end
      ST_CLOSE, ST_ABORT: if (adv) begin
        if (idx_q == BYTE_END) begin
          idx_d = '0;
          st_d  = ST_IDLE;
          gap_d = 1'b1;
        end else idx_d = idx_q + IDX_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
    // Discard the remainder of an aborted packet
    if (drain_q && !fifo_empty_i) begin
      pop_drain = 1'b1;
      if (fifo_last_i) begin
        drain_d = 1'b0;
        gap_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
      last_q  <= 1'b0;
      drain_q <= 1'b0;
      gap_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      last_q  <= last_d;
      drain_q <= drain_d;
      gap_q   <= gap_d;
    end
  end
endmodule

// File: rtl/hdlc_tx_abort_chk.sv
module hdlc_tx_abort_chk
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_stb_i,
  input logic             grant_i,
  input logic             irq_clr_i,
  input logic             fifo_empty_i,
  input logic             fifo_pop_o,
  input logic             req_o,
  input logic             underrun_irq_o,
  input logic             underrun_evt,
  input tx_state_e        st_q,
  input logic [IDX_W-1:0] idx_q
);
  // R2
  no_step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_stb_i && grant_i) |=> $stable(idx_q));

  // R9
  no_empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !fifo_empty_i);

  // R7
  underrun_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_irq_o) |-> $past(fifo_empty_i));

  // R8
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_irq_o && !irq_clr_i) |=> underrun_irq_o);

  // R8
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !underrun_evt) |=> !underrun_irq_o);

  // R10
  release_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && $past(st_q) == ST_CLOSE) |-> !req_o);
endmodule

bind hdlc_tx_abort hdlc_tx_abort_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .bit_stb_i      (bit_stb_i),
  .grant_i        (grant_i),
  .irq_clr_i      (irq_clr_i),
  .fifo_empty_i   (fifo_empty_i),
  .fifo_pop_o     (fifo_pop_o),
  .req_o          (req_o),
  .underrun_irq_o (underrun_irq_o),
  .underrun_evt   (underrun_evt),
  .st_q           (st_q),
  .idx_q          (idx_q)
);

// File: tb/hdlc_tx_abort_test.sv
`timescale 1ns/1ps
module hdlc_tx_abort_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic bit_stb = 1'b0, grant = 1'b0, idle_flag = 1'b0, irq_clr = 1'b0;
  logic [7:0] fifo_data = '0;
  logic fifo_last = 1'b0, fifo_empty = 1'b1;
  logic fifo_pop, req, tx_bit, underrun_irq;

  logic [8:0] fq[$];
  bit         exp_q[$];
  logic [7:0] pkt[$];
  int checks = 0, errors = 0, req_gap_cnt = 0, cyc = 0;
  bit run_en = 0, pop_seen = 0, stb_slow = 0, grant_gaps = 0;
  string stream_tag = "R3";

  hdlc_tx_abort uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(bit_stb), .grant_i(grant),
    .idle_flag_i(idle_flag), .irq_clr_i(irq_clr), .fifo_data_i(fifo_data),
    .fifo_last_i(fifo_last), .fifo_empty_i(fifo_empty), .fifo_pop_o(fifo_pop),
    .req_o(req), .tx_bit_o(tx_bit), .underrun_irq_o(underrun_irq)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic refresh();
    fifo_empty = (fq.size() == 0);
    fifo_last  = (fq.size() != 0) ? fq[0][8] : 1'b0;
    fifo_data  = (fq.size() != 0) ? fq[0][7:0] : 8'h00;
  endtask

  task automatic fpush(logic [7:0] d, logic l);
    fq.push_back({l, d});
    refresh();
  endtask

  // Stimulus pattern for strobe and grant
  always @(posedge clk) begin
    #1;
    cyc++;
    if (run_en) begin
      bit_stb = stb_slow ? (cyc % 3 == 0) : 1'b1;
      grant   = grant_gaps ? (cyc % 7 != 3) : 1'b1;
    end else begin
      bit_stb = 1'b0;
      grant   = 1'b0;
    end
  end

  // FIFO model: pop after the edge that consumed the head
  always @(negedge clk) pop_seen = rst_n && fifo_pop;
  always @(posedge clk) begin
    #1;
    if (pop_seen && fq.size() != 0) begin
      void'(fq.pop_front());
      refresh();
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_pop && fifo_empty) check(1'b0, "R9 pop while empty", 1, 0);
      if (!grant) check(tx_bit === 1'b1, "R2 line high without grant", tx_bit, 1);
      if (bit_stb && grant && exp_q.size() != 0) begin
        bit e;
        e = exp_q.pop_front();
        check(tx_bit === e, stream_tag, tx_bit, e);
      end
      if (!req && fq.size() != 0) req_gap_cnt++;
    end
  end

  // Expected-stream builders
  task automatic push_raw(logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
  endtask

  task automatic push_idle(bit flags);
    push_raw(flags ? 8'h7E : 8'hFF);
  endtask

  task automatic push_stuffed(bit b, ref int ones);
    exp_q.push_back(b);
    ones = b ? ones + 1 : 0;
    if (ones == 5) begin
      exp_q.push_back(1'b0);
      ones = 0;
    end
  endtask

  task automatic push_frame(bit abort);
    int ones = 0;
    logic [15:0] crc = 16'hFFFF;
    logic [15:0] fcs;
    push_raw(8'h7E);
    foreach (pkt[k]) begin
      for (int i = 0; i < 8; i++) begin
        bit b, fb;
        b  = pkt[k][i];
        push_stuffed(b, ones);
        fb = crc[0] ^ b;
        crc = (crc >> 1) ^ (fb ? 16'h8408 : 16'h0000);
      end
    end
    if (!abort) begin
      fcs = ~crc;
      for (int i = 0; i < 16; i++) push_stuffed(fcs[i], ones);
      push_raw(8'h7E);
    end else begin
      push_raw(8'h7F);
    end
  endtask

  task automatic do_reset();
    run_en = 0;
    rst_n  = 1'b0;
    fq.delete();
    exp_q.delete();
    refresh();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic run_stream();
    int t = 0;
    run_en = 1;
    while (exp_q.size() != 0 && t < 20000) begin
      @(posedge clk);
      t++;
    end
    check(exp_q.size() == 0, "R4 stream finished in time", exp_q.size(), 0);
    run_en = 0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    @(negedge clk);
    check(req == 1'b0, "R1 req after reset", req, 0);
    check(fifo_pop == 1'b0, "R1 pop after reset", fifo_pop, 0);
    check(underrun_irq == 1'b0, "R1 irq after reset", underrun_irq, 0);
    check(tx_bit == 1'b1, "R1 line idle without grant", tx_bit, 1);

    // Single frame, flag idle, stuffing in bytes
    do_reset();
    idle_flag = 1'b1;
    fpush(8'h02, 0); fpush(8'hFF, 0); fpush(8'h3F, 0); fpush(8'h7C, 1);
    @(negedge clk);
    check(req == 1'b1, "R10 request raised with data", req, 1);
    pkt = '{8'h02, 8'hFF, 8'h3F, 8'h7C};
    push_idle(1); push_frame(0); push_idle(1); push_idle(1);
    stream_tag = "R3 R4 R5 R6 frame bit";
    @(posedge clk); #1;
    run_stream();
    check(fq.size() == 0, "R4 all bytes consumed", fq.size(), 0);
    check(underrun_irq == 1'b0, "R7 no underrun on complete packet", underrun_irq, 0);

    // Back-to-back packets, ones idle, sparse strobe and grant gaps
    do_reset();
    idle_flag = 1'b0; stb_slow = 1; grant_gaps = 1;
    fpush(8'h7E, 0); fpush(8'h01, 1); fpush(8'hAA, 1);
    req_gap_cnt = 0;
    pkt = '{8'h7E, 8'h01}; push_idle(0); push_frame(0);
    pkt = '{8'hAA};        push_idle(0); push_frame(0); push_idle(0);
    stream_tag = "R2 R3 R11 frame bit";
    @(posedge clk); #1;
    run_stream();
    check(req_gap_cnt == 1, "R10 single release cycle between frames", req_gap_cnt, 1);
    check(fq.size() == 0, "R11 both packets consumed", fq.size(), 0);

    // Underrun: abort, drain, next frame
    do_reset();
    idle_flag = 1'b1; stb_slow = 0; grant_gaps = 0;
    fpush(8'h11, 0); fpush(8'hF8, 0);
    pkt = '{8'h11, 8'hF8}; push_idle(1); push_frame(1);
    pkt = '{8'h55};        push_idle(1); push_frame(0); push_idle(1);
    stream_tag = "R5 R7 R9 frame bit";
    @(posedge clk); #1;
    run_en = 1;
    begin
      int t = 0;
      while (!underrun_irq && t < 5000) begin
        @(posedge clk);
        t++;
      end
    end
    #1;
    check(underrun_irq == 1'b1, "R7 underrun raised", underrun_irq, 1);
    fpush(8'h22, 0); fpush(8'h33, 1); fpush(8'h55, 1);
    run_stream();
    check(fq.size() == 0, "R9 leftover discarded", fq.size(), 0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(underrun_irq == 1'b1, "R8 irq sticky", underrun_irq, 1);
    @(posedge clk); #1 irq_clr = 1'b1;
    @(posedge clk); #1 irq_clr = 1'b0;
    @(negedge clk);
    check(underrun_irq == 1'b0, "R8 irq cleared", underrun_irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule